// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external asynchronous static RAM organised as 128K bytes. The host presents one request at a time over a valid/ready handshake: a 17-bit address, a byte of write data and a direction flag. Read results come back on a byte-wide data output qualified by a one-cycle valid pulse.

On the memory side the controller drives two chip enables of opposite polarity, active-low write and output strobes, the address bus, and a byte-wide data bus that is split into an outgoing value, an output-enable and a sampled input. The pad that joins these into one bidirectional bus sits outside the block. All memory pins are registered, so the strobes change only just after a clock edge and never glitch.

Each phase length is a parameter in nanoseconds. It is converted into whole clock cycles by rounding up against a configurable clock period. The phases are the read access window, the write-strobe width and the bus-release turnaround. Every access starts and ends with the chip deselected. The controller never drives the bus while the memory might still be driving it.

Top module: `asram_bridge`

## Requirements
- R1: After reset and whenever idle, `mem_ce_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `rd_valid`=0 and `req_ready`=1.
- R2: The memory is selected only when `mem_ce_n`=0 and `mem_cs`=1 together. The two enables always change as a pair. The chip is deselected for at least one cycle between accesses.
- R3: A write holds `mem_we_n` low for exactly WP consecutive cycles, where WP is 6 at the default 10 ns clock. `mem_oe_n` stays high for the whole write.
- R4: While `mem_we_n` is low, `mem_dq_oe` is 1 and `mem_dq_out` carries the write byte taken from `req_wdata` at acceptance. A later read of that address returns that byte.
- R5: `mem_addr` is stable while `mem_we_n` is low. It changes only in a cycle where `mem_we_n` was high before and after the change.
- R6: A read holds `mem_oe_n` low with `mem_we_n` high for exactly RA cycles, where RA is 7 at 10 ns. The byte on `mem_dq_in` is sampled at the end of the last of those cycles.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. After `mem_oe_n` rises, at least TA cycles pass before `mem_dq_oe` rises, where TA is 3 at 10 ns.
- R8: A request is taken on a clock edge with `req_valid`=1 and `req_ready`=1. `req_ready` is 0 from the next cycle until the access ends. Changes to `req_addr`, `req_wdata` or `req_write` while busy have no effect on the running access.
- R9: Each phase count is ceil(ns*1000/CLK_PS) with a minimum of 1. The read window is the larger of the address-access and output-enable-access counts. The write strobe is the largest of the strobe-width, address-to-strobe-end, data-setup and cycle-time-minus-two counts.
- R10: `rd_valid` is a single-cycle pulse in the cycle after the read window ends. `rd_data` then holds the sampled byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller can take a request |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 8 | Read result byte |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | 17 | Memory address bus |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | 8 | Byte sampled from the data bus |

## Verification
The bench models the memory so that a read byte becomes valid only after seven cycles of output enable. A design that samples one cycle early returns a junk byte instead of the stored one. A write issued straight after a read is the turnaround corner: skipping the release wait shows as too few quiet cycles between output enable rising and the bus being driven. The host inputs are scrambled while the controller is busy, so a design that reads them live rather than latching them writes or reads the wrong location. Writes and reads at address zero, the top address and alternating bit patterns expose strobe widths that are off by one and address lines that move under a low write strobe.

// File: rtl/asram_pkg.sv
// Shared types and timing helpers for the asynchronous SRAM controller.
// Assumes all timing limits are given in whole nanoseconds and the clock
// period in picoseconds.
package asram_pkg;

    // Controller sequence states
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WR_WAIT   = 3'd1,
        ST_WR_SETUP  = 3'd2,
        ST_WR_PULSE  = 3'd3,
        ST_WR_HOLD   = 3'd4,
        ST_RD_ACCESS = 3'd5
    } asram_state_e;

    // Memory-side control pins as one registered bundle
    typedef struct packed {
        logic ce_n;
        logic cs;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } asram_pins_t;

    // Round a nanosecond limit up to whole clock cycles, at least one
    function automatic int ns_to_cycles(input int ns, input int period_ps);
        int c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    // Larger of two counts
    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pin values that belong to a state
    function automatic asram_pins_t pins_for(input asram_state_e st);
        asram_pins_t p;
        p = '{ce_n: 1'b1, cs: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        case (st)
            ST_WR_SETUP:  p = '{ce_n: 1'b0, cs: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
            ST_WR_PULSE:  p = '{ce_n: 1'b0, cs: 1'b1, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
            ST_WR_HOLD:   p = '{ce_n: 1'b0, cs: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
            ST_RD_ACCESS: p = '{ce_n: 1'b0, cs: 1'b1, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
            default:      ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/asram_timer.sv
// Loadable down-counter that stops at zero.
// Assumes a load takes priority over counting; zero is flagged combinationally.
module asram_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         is_zero
);

    logic [W-1:0] cnt_q;

    // Count down towards zero, or take a new value on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Flag the terminal count
    always_comb begin
        is_zero = (cnt_q == '0);
    end

endmodule

// File: rtl/asram_seq.sv
// Access sequencer: walks read, write and turnaround phases and registers
// the memory control pins from the next state so the strobes are glitch-free.
// Assumes the phase and turnaround timers are external and report zero.
module asram_seq
    import asram_pkg::*;
#(
    parameter int RD_CYC   = 7,
    parameter int WP_CYC   = 6,
    parameter int TURN_CYC = 3,
    parameter int PH_W     = 3,
    parameter int TN_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic            phase_zero,
    input  logic            turn_zero,
    output logic            req_ready,
    output logic            accept,
    output logic            capture,
    output logic            phase_load,
    output logic [PH_W-1:0] phase_val,
    output logic            turn_load,
    output logic [TN_W-1:0] turn_val,
    output asram_pins_t     pins_q
);

    asram_state_e state_q, state_d;

    // Host may hand over a request only while idle
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_valid && req_ready;
    end

    // Next-state and timer-load decisions
    always_comb begin
        state_d    = state_q;
        capture    = 1'b0;
        phase_load = 1'b0;
        phase_val  = '0;
        turn_load  = 1'b0;
        turn_val   = TN_W'(TURN_CYC - 1);
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!req_write) begin
                        state_d    = ST_RD_ACCESS;
                        phase_load = 1'b1;
                        phase_val  = PH_W'(RD_CYC - 1);
                    end else if (turn_zero) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d = ST_WR_WAIT;
                    end
                end
            end
            ST_WR_WAIT: begin
                if (turn_zero) state_d = ST_WR_SETUP;
            end
            ST_WR_SETUP: begin
                state_d    = ST_WR_PULSE;
                phase_load = 1'b1;
                phase_val  = PH_W'(WP_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (phase_zero) state_d = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
            end
            ST_RD_ACCESS: begin
                if (phase_zero) begin
                    state_d   = ST_IDLE;
                    capture   = 1'b1;
                    turn_load = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and pins registered from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pins_q  <= pins_for(ST_IDLE);
        end else begin
            state_q <= state_d;
            pins_q  <= pins_for(state_d);
        end
    end

    // Checker state: cycles the memory outputs have been disabled, saturating
    logic [TN_W:0] quiet_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_q <= (TN_W+1)'(TURN_CYC);
        end else if (!pins_q.oe_n) begin
            quiet_q <= '0;
        end else if (quiet_q < (TN_W+1)'(TURN_CYC)) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    p_enable_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pins_q.ce_n == !pins_q.cs);

    p_oe_off_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_q.we_n |-> pins_q.oe_n);

    p_drive_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_q.we_n |-> pins_q.dq_oe);

    p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pins_q.dq_oe |-> pins_q.oe_n);

    p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pins_q.dq_oe) |-> (quiet_q >= (TN_W+1)'(TURN_CYC)));

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

endmodule

// File: rtl/asram_datapath.sv
// Address, write-data and read-capture registers.
// Assumes accept and capture come from the sequencer and are never both set.
module asram_datapath #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    input  logic              we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    // Latch the request once so host changes while busy are ignored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Sample the bus on the last access cycle and pulse valid once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= mem_dq_in;
        end
    end

    p_addr_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> (we_n && $past(we_n)));

    p_data_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> $stable(mem_dq_out));

    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/asram_bridge.sv
// Top of the asynchronous SRAM controller: converts nanosecond limits to
// cycle counts and joins the sequencer, two timers and the datapath.
// Assumes an external pad joins mem_dq_out/mem_dq_oe/mem_dq_in into one bus.
module asram_bridge
    import asram_pkg::*;
#(
    parameter int ADDR_W          = 17,
    parameter int DATA_W          = 8,
    parameter int CLK_PS          = 10000,
    parameter int T_CYCLE_NS      = 70,
    parameter int T_ADDR_ACC_NS   = 70,
    parameter int T_OE_ACC_NS     = 35,
    parameter int T_WE_LOW_NS     = 60,
    parameter int T_ADDR_SETUP_NS = 60,
    parameter int T_DATA_SETUP_NS = 30,
    parameter int T_RELEASE_NS    = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_ce_n,
    output logic              mem_cs,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int CYC_CYCLE = ns_to_cycles(T_CYCLE_NS, CLK_PS);
    localparam int RD_CYC    = max_of(max_of(ns_to_cycles(T_ADDR_ACC_NS, CLK_PS),
                                             ns_to_cycles(T_OE_ACC_NS, CLK_PS)),
                                      CYC_CYCLE);
    localparam int WP_CYC    = max_of(max_of(ns_to_cycles(T_WE_LOW_NS, CLK_PS),
                                             ns_to_cycles(T_ADDR_SETUP_NS, CLK_PS)),
                                      max_of(ns_to_cycles(T_DATA_SETUP_NS, CLK_PS),
                                             max_of(CYC_CYCLE - 2, 1)));
    localparam int TURN_CYC  = ns_to_cycles(T_RELEASE_NS, CLK_PS);
    localparam int PH_W      = max_of($clog2(max_of(RD_CYC, WP_CYC) + 1), 1);
    localparam int TN_W      = max_of($clog2(TURN_CYC + 1), 1);

    logic            accept, capture;
    logic            phase_load, phase_zero;
    logic [PH_W-1:0] phase_val;
    logic            turn_load, turn_zero;
    logic [TN_W-1:0] turn_val;
    asram_pins_t     pins;

    asram_seq #(
        .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .TURN_CYC(TURN_CYC),
        .PH_W(PH_W), .TN_W(TN_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .phase_zero(phase_zero), .turn_zero(turn_zero),
        .req_ready(req_ready), .accept(accept), .capture(capture),
        .phase_load(phase_load), .phase_val(phase_val),
        .turn_load(turn_load), .turn_val(turn_val),
        .pins_q(pins)
    );

    asram_timer #(.W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n),
        .load(phase_load), .load_val(phase_val), .is_zero(phase_zero)
    );

    asram_timer #(.W(TN_W)) u_turn (
        .clk(clk), .rst_n(rst_n),
        .load(turn_load), .load_val(turn_val), .is_zero(turn_zero)
    );

    asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .capture(capture),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_dq_in(mem_dq_in), .we_n(pins.we_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Fan the registered pin bundle out to the ports
    always_comb begin
        mem_ce_n  = pins.ce_n;
        mem_cs    = pins.cs;
        mem_we_n  = pins.we_n;
        mem_oe_n  = pins.oe_n;
        mem_dq_oe = pins.dq_oe;
    end

    p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe));

    p_capture_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!mem_oe_n) && $past(mem_we_n)));

endmodule

// File: tb/tb_asram_bridge.sv
module tb_asram_bridge;

    // Expected cycle counts worked out from the ns limits at a 10 ns clock (R9)
    function automatic int up_cyc(input int ns);
        int c;
        c = (ns * 1000 + 9999) / 10000;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int EXP_RA = up_cyc(70);
    localparam int EXP_WP = up_cyc(60);
    localparam int EXP_TA = up_cyc(25);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic        mem_ce_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    logic [7:0] ref_mem [bit [16:0]];
    logic [7:0] model_mem [bit [16:0]];

    always #5 clk = ~clk;

    asram_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_ce_n(mem_ce_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Memory model and protocol monitor, evaluated away from the active edge
    int  oe_low = 0, we_low = 0, oe_high = 1000;
    bit  prev_dq_oe = 0, prev_valid = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            check(mem_ce_n == !mem_cs, "R2 enables paired", mem_ce_n, !mem_cs);
            if (req_ready)
                check(mem_ce_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe,
                      "R1 idle pins", {mem_ce_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
            if (mem_dq_oe && !prev_dq_oe)
                check(oe_high >= EXP_TA, "R7 turnaround", oe_high, EXP_TA);
            if (mem_dq_oe)
                check(mem_oe_n, "R7 no contention", mem_oe_n, 1);
            // write strobe model: last byte seen while low is stored
            if (!mem_we_n && !mem_ce_n && mem_cs) begin
                we_low++;
                check(mem_dq_oe && mem_oe_n, "R4 bus driven in write", {mem_dq_oe, mem_oe_n}, 2'b11);
                model_mem[mem_addr] = mem_dq_out;
            end else if (we_low != 0) begin
                check(we_low == EXP_WP, "R3 strobe width", we_low, EXP_WP);
                we_low = 0;
            end
            // read model: byte valid only after EXP_RA cycles of output enable
            if (!mem_oe_n && mem_we_n && !mem_ce_n && mem_cs) begin
                oe_low++;
                oe_high = 0;
                mem_dq_in = (oe_low >= EXP_RA && model_mem.exists(mem_addr)) ? model_mem[mem_addr] : 8'hEE;
            end else begin
                if (oe_low != 0)
                    check(oe_low == EXP_RA, "R6 read window", oe_low, EXP_RA);
                oe_low = 0;
                if (mem_oe_n && oe_high < 1000) oe_high++;
                mem_dq_in = 8'hEE;
            end
            // scoreboard pop
            if (rd_valid) begin
                check(!prev_valid, "R10 single pulse", prev_valid, 0);
                if (exp_q.size() == 0) begin
                    check(0, "R6 unexpected read", rd_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R6 read data", rd_data, e);
                end
            end
            prev_valid = rd_valid;
            prev_dq_oe = mem_dq_oe;
        end
    end

    // Driver: issue one request, scramble inputs while busy (R8), wait for completion
    task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        if (wr) ref_mem[a] = d;
        else exp_q.push_back(ref_mem.exists(a) ? ref_mem[a] : 8'h00);
        @(negedge clk);
        req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
        check(!req_ready, "R8 busy after accept", req_ready, 0);
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mem_ce_n == 1'b1, "R1 ce_n reset", mem_ce_n, 1);
        check(mem_cs == 1'b0, "R1 cs reset", mem_cs, 0);
        check(mem_we_n && mem_oe_n, "R1 strobes reset", {mem_we_n, mem_oe_n}, 2'b11);
        check(!mem_dq_oe && !rd_valid, "R1 bus released", {mem_dq_oe, rd_valid}, 0);
        check(req_ready, "R1 ready", req_ready, 1);
        // writes at the boundaries and alternating patterns (R3 R4 R5)
        issue(1, 17'h00000, 8'h00);
        issue(1, 17'h1FFFF, 8'hFF);
        issue(1, 17'h0AAAA, 8'hA5);
        issue(1, 17'h15555, 8'h5A);
        // back-to-back reads (R6 R10)
        issue(0, 17'h00000, 8'h00);
        issue(0, 17'h1FFFF, 8'h00);
        issue(0, 17'h0AAAA, 8'h00);
        // write straight after a read exercises the turnaround (R7)
        issue(1, 17'h00000, 8'h3C);
        issue(0, 17'h15555, 8'h00);
        issue(1, 17'h00001, 8'hC3);
        issue(0, 17'h00000, 8'h00);
        issue(0, 17'h00001, 8'h00);
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
        check(mem_ce_n && !mem_cs, "R2 deselected at end", {mem_ce_n, mem_cs}, 2'b10);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule